// File: doc/BRIEF.md
# User/Kernel Privilege Access Checker

This block holds the processor's privilege mode bit and checks every request of the current cycle against it. A request is described by its effective address, three access-kind flags (instruction fetch, data load, data store), a flag that says the opcode decoded to a defined instruction, and a flag that says the instruction touches the system-control coprocessor registers. When the request breaks the two-mode rule, the block raises a fault and gives the exception cause code in the same cycle. The exception sequencer uses that code to start its own work.

The mode bit lives inside the block. Value 0 is kernel mode and value 1 is user mode. The bit clears on reset and on every exception entry. A write strobe from the instruction that leaves the kernel is the only way to set it. Address space is split by the top address bit alone: the lower half is open to both modes, and the upper half is open to kernel mode only.

The reset input clears the mode at once. Its release passes through a two-stage synchronizer first.

Top module: `priv_access_checker`

## Requirements
- R1: `user_mode_o` is 0 (kernel) while `rst_n` is low and after its release, until a user-mode write strobe is taken.
- R2: `exc_entry_i` high at a rising clock edge makes `user_mode_o` 0 from that edge onward. This holds even when `set_user_i` is high in the same cycle.
- R3: `set_user_i` high with `exc_entry_i` low at a rising edge makes `user_mode_o` 1 from that edge. With both strobes low, the mode keeps its value.
- R4: In kernel mode (`user_mode_o`=0), a request with `opcode_ok_i`=1 never faults, whatever its address or its `cp0_acc_i` value.
- R5: In user mode, a fetch or a load whose address has bit 31 set faults with cause 4. A store to such an address faults with cause 5. When load or fetch and store are all flagged, the result is cause 4.
- R6: In user mode, addresses with bit 31 clear never raise an address error.
- R7: In user mode, `cp0_acc_i`=1 faults with cause 10 (reserved instruction).
- R8: `opcode_ok_i`=0 faults with cause 10 in either mode.
- R9: A fetch address error (cause 4) takes priority over a reserved-instruction fault. A reserved-instruction fault (cause 10) takes priority over a load or store address error.
- R10: `fault_o` and `cause_o` depend only on the present inputs and the present mode, with no added cycle. With no fault, `cause_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| exc_entry_i | input | 1 | Exception entry strobe, forces kernel mode |
| set_user_i | input | 1 | Write strobe that sets user mode |
| addr_i | input | 32 | Effective address of the request |
| fetch_i | input | 1 | Request is an instruction fetch |
| load_i | input | 1 | Request is a data load |
| store_i | input | 1 | Request is a data store |
| opcode_ok_i | input | 1 | Opcode is a defined instruction |
| cp0_acc_i | input | 1 | Instruction accesses system-control registers |
| user_mode_o | output | 1 | Current mode: 0 kernel, 1 user |
| fault_o | output | 1 | Request violates privilege rules |
| cause_o | output | 5 | Exception cause code, 0 when no fault |

## Verification
The assertions check several properties on every cycle. They check how the mode register moves under the two strobes, with exception entry beating the write strobe. They check that kernel mode with a valid opcode never faults, and that the cause code is 0 exactly when there is no fault and is otherwise one of 4, 5 or 10. They also check that a user fetch from the upper half always reports cause 4. Other behaviours can only be shown by the bench's scenarios: the reset state, including an asynchronous reset in the middle of user mode; the distinction between load and store codes; the priority order when several faults overlap; and the edge addresses 0x7FFFFFFF and 0x80000000.

// File: rtl/priv_pkg.sv
package priv_pkg;

  localparam int unsigned CAUSE_W = 5;

  typedef logic [CAUSE_W-1:0] cause_t;

  localparam cause_t CAUSE_NONE     = cause_t'(0);
  localparam cause_t CAUSE_ADEL     = cause_t'(4);
  localparam cause_t CAUSE_ADES     = cause_t'(5);
  localparam cause_t CAUSE_RESERVED = cause_t'(10);

  typedef enum logic {
    MODE_KERNEL = 1'b0,
    MODE_USER   = 1'b1
  } priv_mode_e;

  typedef struct packed {
    logic fetch_err;
    logic load_err;
    logic store_err;
  } addr_err_t;

endpackage

// File: rtl/priv_rst_sync.sv
module priv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/priv_mode_reg.sv
module priv_mode_reg
  import priv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exc_entry_i,
  input  logic       set_user_i,
  output priv_mode_e mode_o
);

  priv_mode_e mode_q;
  priv_mode_e mode_d;
  logic       mode_en;

  // Exception entry outranks the user-mode write strobe.
  always_comb begin
    mode_en = exc_entry_i | set_user_i;
    if (exc_entry_i) begin
      mode_d = MODE_KERNEL;
    end else begin
      mode_d = MODE_USER;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_KERNEL;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/priv_addr_chk.sv
module priv_addr_chk
  import priv_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              user_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              fetch_i,
  input  logic              load_i,
  input  logic              store_i,
  output addr_err_t         err_o
);

  localparam int unsigned KSEG_BIT = ADDR_W - 1;

  logic kernel_region;
  logic blocked;

  always_comb begin
    kernel_region     = addr_i[KSEG_BIT];
    blocked           = user_i & kernel_region;
    err_o.fetch_err   = blocked & fetch_i;
    err_o.load_err    = blocked & load_i;
    err_o.store_err   = blocked & store_i;
  end

endmodule

// File: rtl/priv_instr_chk.sv
module priv_instr_chk (
  input  logic user_i,
  input  logic opcode_ok_i,
  input  logic cp0_acc_i,
  output logic reserved_o
);

  logic undefined_op;
  logic cp0_in_user;

  always_comb begin
    undefined_op = ~opcode_ok_i;
    cp0_in_user  = user_i & cp0_acc_i;
    reserved_o   = undefined_op | cp0_in_user;
  end

endmodule

// File: rtl/priv_access_checker.sv
module priv_access_checker
  import priv_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_entry_i,
  input  logic              set_user_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              fetch_i,
  input  logic              load_i,
  input  logic              store_i,
  input  logic              opcode_ok_i,
  input  logic              cp0_acc_i,
  output logic              user_mode_o,
  output logic              fault_o,
  output logic [CAUSE_W-1:0] cause_o
);

  logic       rst_q_n;
  priv_mode_e mode;
  logic       is_user;
  addr_err_t  aerr;
  logic       rsvd;
  cause_t     cause_d;

  priv_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  priv_mode_reg u_mode (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .exc_entry_i (exc_entry_i),
    .set_user_i  (set_user_i),
    .mode_o      (mode)
  );

  assign is_user = (mode == MODE_USER);

  priv_addr_chk #(
    .ADDR_W (ADDR_W)
  ) u_addr (
    .user_i  (is_user),
    .addr_i  (addr_i),
    .fetch_i (fetch_i),
    .load_i  (load_i),
    .store_i (store_i),
    .err_o   (aerr)
  );

  priv_instr_chk u_instr (
    .user_i      (is_user),
    .opcode_ok_i (opcode_ok_i),
    .cp0_acc_i   (cp0_acc_i),
    .reserved_o  (rsvd)
  );

  // Priority: fetch address error, reserved instruction, load, store.
  always_comb begin
    if (aerr.fetch_err) begin
      cause_d = CAUSE_ADEL;
    end else if (rsvd) begin
      cause_d = CAUSE_RESERVED;
    end else if (aerr.load_err) begin
      cause_d = CAUSE_ADEL;
    end else if (aerr.store_err) begin
      cause_d = CAUSE_ADES;
    end else begin
      cause_d = CAUSE_NONE;
    end
  end

  assign user_mode_o = is_user;
  assign fault_o     = rsvd | aerr.fetch_err | aerr.load_err | aerr.store_err;
  assign cause_o     = cause_d;

endmodule

// File: rtl/priv_access_checker_sva.sv
module priv_access_checker_sva #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exc_entry_i,
  input logic              set_user_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              fetch_i,
  input logic              opcode_ok_i,
  input logic              user_mode_o,
  input logic              fault_o,
  input logic [4:0]        cause_o
);

  // R2
  exc_to_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry_i |=> !user_mode_o);

  // R3
  set_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_user_i && !exc_entry_i) |=> user_mode_o);

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_user_i && !exc_entry_i) |=> $stable(user_mode_o));

  // R4
  kernel_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_mode_o && opcode_ok_i) |-> !fault_o);

  // R10
  cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_o |-> (cause_o == 5'd0));

  // R10
  cause_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (cause_o == 5'd4 || cause_o == 5'd5 || cause_o == 5'd10));

  // R9
  fetch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode_o && fetch_i && addr_i[ADDR_W-1]) |-> (cause_o == 5'd4));

endmodule

bind priv_access_checker priv_access_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .exc_entry_i (exc_entry_i),
  .set_user_i  (set_user_i),
  .addr_i      (addr_i),
  .fetch_i     (fetch_i),
  .opcode_ok_i (opcode_ok_i),
  .user_mode_o (user_mode_o),
  .fault_o     (fault_o),
  .cause_o     (cause_o)
);

// File: tb/priv_access_checker_test.sv
`timescale 1ns/1ps
module priv_access_checker_test;

  logic        clk;
  logic        rst_n;
  logic        exc_entry_i;
  logic        set_user_i;
  logic [31:0] addr_i;
  logic        fetch_i;
  logic        load_i;
  logic        store_i;
  logic        opcode_ok_i;
  logic        cp0_acc_i;
  logic        user_mode_o;
  logic        fault_o;
  logic [4:0]  cause_o;

  int checks;
  int errors;
  bit done;

  priv_access_checker uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_entry_i (exc_entry_i),
    .set_user_i  (set_user_i),
    .addr_i      (addr_i),
    .fetch_i     (fetch_i),
    .load_i      (load_i),
    .store_i     (store_i),
    .opcode_ok_i (opcode_ok_i),
    .cp0_acc_i   (cp0_acc_i),
    .user_mode_o (user_mode_o),
    .fault_o     (fault_o),
    .cause_o     (cause_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_req();
    addr_i = 32'h0; fetch_i = 0; load_i = 0; store_i = 0;
    opcode_ok_i = 1; cp0_acc_i = 0;
  endtask

  // Apply a request after a falling edge and check the outputs combinationally.
  task automatic req(input string tag, input logic [31:0] a, input logic f,
                     input logic l, input logic s, input logic ok, input logic c,
                     input int exp_fault, input int exp_cause);
    @(negedge clk);
    addr_i = a; fetch_i = f; load_i = l; store_i = s; opcode_ok_i = ok; cp0_acc_i = c;
    #1;
    chk({tag, " fault"}, int'(fault_o), exp_fault);
    chk({tag, " cause"}, int'(cause_o), exp_cause);
    idle_req();
  endtask

  task automatic strobe(input logic exc, input logic su);
    @(negedge clk);
    exc_entry_i = exc; set_user_i = su;
    @(negedge clk);
    exc_entry_i = 0; set_user_i = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 mode in reset", int'(user_mode_o), 0);
    do_reset();
    chk("R1 mode after release", int'(user_mode_o), 0);
  endtask

  task automatic t_mode_seq();
    strobe(0, 1);
    chk("R3 set user", int'(user_mode_o), 1);
    repeat (3) @(negedge clk);
    chk("R3 hold user", int'(user_mode_o), 1);
    strobe(1, 0);
    chk("R2 exception entry", int'(user_mode_o), 0);
    strobe(0, 1);
    strobe(1, 1);
    chk("R2 exception beats write", int'(user_mode_o), 0);
    strobe(0, 1);
    @(negedge clk);
    rst_n = 0;
    #1;
    chk("R1 async reset mid-run", int'(user_mode_o), 0);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 kernel after re-reset", int'(user_mode_o), 0);
  endtask

  task automatic t_kernel();
    req("R4 kernel load high", 32'hFFFF_FFF0, 0, 1, 0, 1, 0, 0, 0);
    req("R4 kernel store high", 32'h8000_0000, 0, 0, 1, 1, 0, 0, 0);
    req("R4 kernel fetch cp0", 32'h8000_0180, 1, 0, 0, 1, 1, 0, 0);
    req("R8 kernel undefined", 32'h0000_1000, 1, 0, 0, 0, 0, 1, 10);
  endtask

  task automatic t_user_addr();
    strobe(0, 1);
    chk("R3 user for addr tests", int'(user_mode_o), 1);
    req("R5 user load", 32'h8000_0000, 0, 1, 0, 1, 0, 1, 4);
    req("R5 user fetch", 32'hC000_0004, 1, 0, 0, 1, 0, 1, 4);
    req("R5 user store", 32'hFFFF_FFFC, 0, 0, 1, 1, 0, 1, 5);
    req("R5 load+store", 32'h9000_0000, 0, 1, 1, 1, 0, 1, 4);
    req("R6 user top of low", 32'h7FFF_FFFF, 0, 1, 0, 1, 0, 0, 0);
    req("R6 user store low", 32'h1234_5678, 0, 0, 1, 1, 0, 0, 0);
    req("R6 user fetch low", 32'h0040_0000, 1, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_user_instr();
    req("R7 user cp0", 32'h0040_0010, 1, 0, 0, 1, 1, 1, 10);
    req("R8 user undefined", 32'h0040_0014, 1, 0, 0, 0, 0, 1, 10);
    req("R10 no request", 32'h8000_0000, 0, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_priority();
    req("R9 fetch AE over RI", 32'h8000_0010, 1, 0, 0, 0, 1, 1, 4);
    req("R9 RI over load AE", 32'h8000_0020, 0, 1, 0, 1, 1, 1, 10);
    req("R9 RI over store AE", 32'h8000_0030, 0, 0, 1, 0, 0, 1, 10);
    strobe(1, 0);
    req("R2 kernel after entry", 32'h8000_0030, 0, 0, 1, 1, 1, 0, 0);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 0; exc_entry_i = 0; set_user_i = 0;
    idle_req();
    #2;
    t_reset();
    t_mode_seq();
    t_kernel();
    t_user_addr();
    t_user_instr();
    t_priority();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule